// File: doc/BRIEF.md
# TDM Frame-Aligned Serial Receiver

This block receives a time-division multiplexed serial stream that carries four 24-bit channel words per frame. A bit clock, a data line and a frame-marker line come from an external transmitter. All three are brought into the system clock domain through a synchronizer chain, and the block finds the bit-clock rising edges there. Each finished word leaves on a valid/ready output with its channel index and a flag that marks the first word of a frame.

The key property is that channel numbering cannot rotate. When enable is raised, the block is only armed. Capture starts at the next rising edge of the frame marker, so the first word delivered is always channel 0, and it does not matter where in a frame the enable arrived. A frame marker that arrives early resynchronizes the block and reports the fault. The partial frame is thrown away, and no word is delivered under the wrong index.

Top module: `tdm_frame_rx`

## Requirements
- R1: A frame is 4 words of 24 bits each, sent most significant bit first. `ser_data` and `ser_fsync` are sampled at each rising edge of `ser_clk`, and the transmitter changes them on falling edges. Each half period of `ser_clk` must last at least 3 system clocks.
- R2: A rising edge of `ser_fsync` (high at a sample, low at the previous sample) marks bit 0 of channel 0. Words of a frame are delivered with `out_chan` = 0, 1, 2, 3 in that order, and `out_first` is 1 exactly when `out_chan` is 0.
- R3: Raising `enable` only arms the receiver. Bits that arrive before the next frame-marker rising edge produce no output words.
- R4: `out_data` carries the 24-bit word in bits 23..0, and bits 31..24 are 0.
- R5: After the fourth word of a frame, the block waits for another frame-marker rising edge. Bits that arrive with no such edge produce no words.
- R6: A frame-marker rising edge before the fourth word completes raises `sync_error` for one cycle, discards the partial word, and restarts capture at channel 0 with the current bit.
- R7: A frame marker held high for several bit periods counts as a single rising edge and raises no `sync_error`.
- R8: A low `enable` returns the block to its disabled state at the next clock. This drops any partial word, clears `out_valid` and clears `overflow`. Raising `enable` again re-arms the block as in R3.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_data`, `out_chan` and `out_first` keep their values.
- R10: If a word completes while the held word is still unaccepted, `overflow` becomes 1 and the new word is dropped. `overflow` stays 1 until `enable` goes low.
- R11: After reset, `out_valid`, `overflow` and `sync_error` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Arms reception when high; disables the block when low |
| ser_clk | input | 1 | External bit clock |
| ser_data | input | 1 | Serial data line |
| ser_fsync | input | 1 | Frame marker line |
| out_ready | input | 1 | Consumer accepts the held word |
| out_valid | output | 1 | A word is held on the output |
| out_data | output | 32 | Received word, zero-extended |
| out_chan | output | 2 | Channel index of the held word |
| out_first | output | 1 | Held word is channel 0 |
| overflow | output | 1 | Sticky flag: a word was lost to back-pressure |
| sync_error | output | 1 | One-cycle pulse on an early frame marker |

## Verification
The bench enables the block in the middle of a frame. A design that began capture at once would deliver rotated channels, and a later word would come out tagged as channel 0. It cuts one frame short with an early frame marker and checks that only the finished words come out, that exactly one error pulse appears, and that the next frame starts cleanly at channel 0. A design that kept the partial word or counted from the wrong slot fails here. It also sends a frame marker several bits long, which an edge detector that fires on level would flag as an error. Finally it holds `out_ready` low across a whole frame, where a design that overwrote the held word or cleared the sticky flag would show the wrong data or lose the overflow indication.

// File: rtl/tdmrx_pkg.sv
package tdmrx_pkg;
  localparam int unsigned NUM_CH = 4;
  localparam int unsigned WORD_W = 24;
  localparam int unsigned OUT_W  = 32;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_RECV  = 2'd2,
    ST_WAIT  = 2'd3
  } rx_state_e;
endpackage

// File: rtl/tdmrx_pin_sync.sv
module tdmrx_pin_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_pin
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else if (STAGES > 1) chain_q <= {chain_q[STAGES-2:0], din[g]};
      else chain_q <= din[g];
    end
    assign dout[g] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/tdmrx_framer.sv
module tdmrx_framer
  import tdmrx_pkg::*;
#(
  parameter int unsigned CHANNELS = NUM_CH,
  parameter int unsigned BITS     = WORD_W
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        en,
  input  logic                        sclk_s,
  input  logic                        data_s,
  input  logic                        fs_s,
  output logic                        word_done,
  output logic [BITS-1:0]             word_data,
  output logic [$clog2(CHANNELS)-1:0] word_chan,
  output logic                        sync_err
);
  localparam int unsigned CW  = $clog2(CHANNELS);
  localparam int unsigned BCW = $clog2(BITS);
  localparam logic [BCW-1:0] LAST_BIT = BCW'(BITS - 1);
  localparam logic [CW-1:0]  LAST_CH  = CW'(CHANNELS - 1);

  rx_state_e      state_q, state_n;
  logic [BCW-1:0] bcnt_q, bcnt_n;
  logic [CW-1:0]  chan_q, chan_n;
  logic [BITS-1:0] shr_q, shr_n;
  logic           sclk_prev_q, fs_prev_q, fs_prev_n;
  logic           done_n, serr_n;
  logic [BITS-1:0] wdata_n;
  logic [CW-1:0]  wchan_n;
  logic           samp, fs_rise;
  logic [BITS-1:0] shifted;

  assign samp    = sclk_s & ~sclk_prev_q;
  assign fs_rise = samp & fs_s & ~fs_prev_q;
  assign shifted = {shr_q[BITS-2:0], data_s};

  always_comb begin
    state_n   = state_q;
    bcnt_n    = bcnt_q;
    chan_n    = chan_q;
    shr_n     = shr_q;
    fs_prev_n = samp ? fs_s : fs_prev_q;
    done_n    = 1'b0;
    serr_n    = 1'b0;
    wdata_n   = word_data;
    wchan_n   = word_chan;
    if (!en) begin
      state_n = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: state_n = ST_ARMED;
        ST_ARMED, ST_WAIT: begin
          if (fs_rise) begin
            state_n = ST_RECV;
            shr_n   = {{(BITS-1){1'b0}}, data_s};
            bcnt_n  = BCW'(1);
            chan_n  = '0;
          end
        end
        ST_RECV: begin
          if (fs_rise) begin
            serr_n = 1'b1;
            shr_n  = {{(BITS-1){1'b0}}, data_s};
            bcnt_n = BCW'(1);
            chan_n = '0;
          end else if (samp) begin
            shr_n = shifted;
            if (bcnt_q == LAST_BIT) begin
              done_n  = 1'b1;
              wdata_n = shifted;
              wchan_n = chan_q;
              bcnt_n  = '0;
              if (chan_q == LAST_CH) state_n = ST_WAIT;
              else chan_n = chan_q + CW'(1);
            end else begin
              bcnt_n = bcnt_q + BCW'(1);
            end
          end
        end
        default: state_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      bcnt_q      <= '0;
      chan_q      <= '0;
      shr_q       <= '0;
      sclk_prev_q <= 1'b0;
      fs_prev_q   <= 1'b0;
      word_done   <= 1'b0;
      word_data   <= '0;
      word_chan   <= '0;
      sync_err    <= 1'b0;
    end else begin
      state_q     <= state_n;
      bcnt_q      <= bcnt_n;
      chan_q      <= chan_n;
      shr_q       <= shr_n;
      sclk_prev_q <= sclk_s;
      fs_prev_q   <= fs_prev_n;
      word_done   <= done_n;
      word_data   <= wdata_n;
      word_chan   <= wchan_n;
      sync_err    <= serr_n;
    end
  end

  // R8: disable forces the idle state on the following edge
  p_idle_on_disable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> state_q == ST_IDLE);
  // R3: an armed receiver never completes a word on the next cycle
  p_armed_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_ARMED |=> !word_done);
  // R6: the error flag lasts a single cycle
  p_serr_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sync_err |=> !sync_err);
  // R5: the last word of a frame leaves the receiver waiting for a marker
  p_wait_after_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && word_chan == LAST_CH) |-> state_q == ST_WAIT);
endmodule

// File: rtl/tdmrx_out_hold.sv
module tdmrx_out_hold #(
  parameter int unsigned BITS = 24,
  parameter int unsigned OUTW = 32,
  parameter int unsigned CW   = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            word_in,
  input  logic [BITS-1:0] data_in,
  input  logic [CW-1:0]   chan_in,
  input  logic            ready,
  output logic            valid,
  output logic [OUTW-1:0] data,
  output logic [CW-1:0]   chan,
  output logic            ovf
);
  logic            valid_n, ovf_n;
  logic [OUTW-1:0] data_n;
  logic [CW-1:0]   chan_n;
  logic            busy;

  assign busy = valid & ~ready;

  always_comb begin
    valid_n = valid;
    ovf_n   = ovf;
    data_n  = data;
    chan_n  = chan;
    if (!en) begin
      valid_n = 1'b0;
      ovf_n   = 1'b0;
    end else begin
      if (valid && ready) valid_n = 1'b0;
      if (word_in) begin
        if (busy) begin
          ovf_n = 1'b1;
        end else begin
          valid_n = 1'b1;
          data_n  = {{(OUTW-BITS){1'b0}}, data_in};
          chan_n  = chan_in;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid <= 1'b0;
      ovf   <= 1'b0;
      data  <= '0;
      chan  <= '0;
    end else begin
      valid <= valid_n;
      ovf   <= ovf_n;
      if (valid_n && !busy) begin
        data <= data_n;
        chan <= chan_n;
      end
    end
  end

  // R9: a stalled word stays put
  p_hold_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready && en) |=> (valid && $stable(data) && $stable(chan)));
  // R10: overflow is sticky while enabled
  p_overflow_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && en) |=> ovf);
  // R4: the pad bits above the word are zero
  p_upper_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> data[OUTW-1:BITS] == '0);
endmodule

// File: rtl/tdm_frame_rx.sv
module tdm_frame_rx
  import tdmrx_pkg::*;
#(
  parameter int unsigned CHANNELS    = NUM_CH,
  parameter int unsigned BITS        = WORD_W,
  parameter int unsigned OUTW        = OUT_W,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        enable,
  input  logic                        ser_clk,
  input  logic                        ser_data,
  input  logic                        ser_fsync,
  input  logic                        out_ready,
  output logic                        out_valid,
  output logic [OUTW-1:0]             out_data,
  output logic [$clog2(CHANNELS)-1:0] out_chan,
  output logic                        out_first,
  output logic                        overflow,
  output logic                        sync_error
);
  localparam int unsigned CW = $clog2(CHANNELS);

  logic [2:0]      pins_s;
  logic            word_done;
  logic [BITS-1:0] word_data;
  logic [CW-1:0]   word_chan;

  tdmrx_pin_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({ser_fsync, ser_data, ser_clk}),
    .dout (pins_s)
  );

  tdmrx_framer #(.CHANNELS(CHANNELS), .BITS(BITS)) u_framer (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (enable),
    .sclk_s   (pins_s[0]),
    .data_s   (pins_s[1]),
    .fs_s     (pins_s[2]),
    .word_done(word_done),
    .word_data(word_data),
    .word_chan(word_chan),
    .sync_err (sync_error)
  );

  tdmrx_out_hold #(.BITS(BITS), .OUTW(OUTW), .CW(CW)) u_out (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (enable),
    .word_in(word_done),
    .data_in(word_data),
    .chan_in(word_chan),
    .ready  (out_ready),
    .valid  (out_valid),
    .data   (out_data),
    .chan   (out_chan),
    .ovf    (overflow)
  );

  assign out_first = (out_chan == '0);
endmodule

// File: tb/tdm_frame_rx_tb.sv
module tdm_frame_rx_tb;
  logic        clk = 1'b0;
  logic        rst_n, enable, ser_clk, ser_data, ser_fsync, rdy;
  logic        out_valid, out_first, overflow, sync_error;
  logic [31:0] out_data;
  logic [1:0]  out_chan;

  int checks = 0;
  int errors = 0;
  int serr_cnt = 0;
  logic [25:0] expq[$];

  always #2.5 clk = ~clk;

  tdm_frame_rx u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .ser_clk(ser_clk),
    .ser_data(ser_data), .ser_fsync(ser_fsync), .out_ready(rdy),
    .out_valid(out_valid), .out_data(out_data), .out_chan(out_chan),
    .out_first(out_first), .overflow(overflow), .sync_error(sync_error)
  );

  function automatic logic [23:0] wv(input int f, input int c);
    logic [31:0] t;
    t = (f * 32'h0001F3A5 + c * 32'h000C3A1 + 32'h111111) ^ 32'h5A5A5A;
    return t[23:0];
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (sync_error) serr_cnt++;
    if (rst_n && out_valid && rdy) begin
      if (expq.size() == 0) begin
        check(1'b0, "R3/R5 unexpected word", {out_chan, out_data[29:0]}, 32'h0);
      end else begin
        logic [25:0] e;
        e = expq.pop_front();
        check(out_data == {8'h00, e[23:0]}, "R1/R4 word data", out_data, {8'h00, e[23:0]});
        check(out_chan == e[25:24], "R2 channel index", 32'(out_chan), 32'(e[25:24]));
        check(out_first == (e[25:24] == 2'd0), "R2 first flag", 32'(out_first), 32'(e[25:24] == 2'd0));
      end
    end
  end

  task automatic drive_bit(input logic d, input logic fs);
    ser_data = d; ser_fsync = fs;
    repeat (4) @(negedge clk);
    ser_clk = 1'b1;
    repeat (4) @(negedge clk);
    ser_clk = 1'b0;
  endtask

  task automatic idle_bits(input int n);
    for (int i = 0; i < n; i++) drive_bit(i[0] ^ i[2], 1'b0);
  endtask

  task automatic send_frame(input int f, input int nbits, input logic [3:0] mask,
                            input int fslen, input int en_on, input int en_off);
    for (int b = 0; b < nbits; b++) begin
      int ch;
      logic [23:0] w;
      ch = b / 24;
      w  = wv(f, ch);
      if (b == en_on)  enable = 1'b1;
      if (b == en_off) enable = 1'b0;
      if ((b % 24) == 23 && mask[ch]) expq.push_back({2'(ch), w});
      drive_bit(w[23 - (b % 24)], b < fslen);
    end
  endtask

  task automatic settle();
    repeat (20) @(negedge clk);
    check(expq.size() == 0, "R2 all expected words delivered", 32'(expq.size()), 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; enable = 1'b0; rdy = 1'b1;
    ser_clk = 1'b0; ser_data = 1'b0; ser_fsync = 1'b0;
    repeat (10) @(negedge clk);
    check(out_valid == 1'b0, "R11 reset valid", 32'(out_valid), 32'h0);
    check(overflow == 1'b0, "R11 reset overflow", 32'(overflow), 32'h0);
    check(sync_error == 1'b0, "R11 reset sync_error", 32'(sync_error), 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 R2 R4 R5: aligned frames, gaps without markers in between
    enable = 1'b1;
    idle_bits(5);
    send_frame(0, 96, 4'hF, 1, -1, -1);
    send_frame(1, 96, 4'hF, 1, -1, -1);
    idle_bits(10);
    send_frame(2, 96, 4'hF, 1, -1, -1);
    settle();

    // R7: long marker pulse is one edge
    send_frame(3, 96, 4'hF, 3, -1, -1);
    send_frame(4, 96, 4'hF, 1, -1, -1);
    settle();
    check(serr_cnt == 0, "R7 no sync_error on long marker", 32'(serr_cnt), 32'h0);

    // R6: early marker after two words and ten bits
    send_frame(5, 58, 4'b0011, 1, -1, -1);
    send_frame(6, 96, 4'hF, 1, -1, -1);
    settle();
    check(serr_cnt == 1, "R6 one sync_error pulse", 32'(serr_cnt), 32'h1);

    // R3: enable in mid-frame yields nothing until the next marker
    enable = 1'b0;
    idle_bits(3);
    send_frame(7, 96, 4'b0000, 1, 30, -1);
    send_frame(8, 96, 4'hF, 1, -1, -1);
    settle();

    // R8: disable mid-word drops it, re-enable re-arms
    send_frame(9, 96, 4'b0001, 1, 50, 30);
    send_frame(10, 96, 4'hF, 1, -1, -1);
    settle();

    // R3: disabled block ignores a full frame
    enable = 1'b0;
    send_frame(11, 96, 4'b0000, 1, -1, -1);
    settle();
    enable = 1'b1;
    idle_bits(2);

    // R9 R10: back-pressure across a whole frame
    @(posedge clk); #1 rdy = 1'b0;
    send_frame(12, 96, 4'b0001, 1, -1, -1);
    repeat (20) @(negedge clk);
    check(out_valid == 1'b1, "R9 word held while stalled", 32'(out_valid), 32'h1);
    check(out_data == {8'h00, wv(12, 0)}, "R10 held word kept, later dropped", out_data, {8'h00, wv(12, 0)});
    check(overflow == 1'b1, "R10 overflow set", 32'(overflow), 32'h1);
    @(posedge clk); #1 rdy = 1'b1;
    settle();
    check(out_valid == 1'b0, "R9 valid clears after accept", 32'(out_valid), 32'h0);
    check(overflow == 1'b1, "R10 overflow sticky", 32'(overflow), 32'h1);
    enable = 1'b0;
    repeat (3) @(negedge clk);
    check(overflow == 1'b0, "R8 disable clears overflow", 32'(overflow), 32'h0);
    enable = 1'b1;
    idle_bits(2);

    // R2: normal operation resumes
    send_frame(13, 96, 4'hF, 1, -1, -1);
    settle();
    check(serr_cnt == 1, "R6 no further sync_error", 32'(serr_cnt), 32'h1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule